// File: doc/BRIEF.md
# Circular Comparison Response Analyzer

This block is a self-test harness for a ring of identical blocks under test. One pattern source feeds every block the same stimulus for a programmable number of cycles. Around a closed ring, each block's output is compared with the output of the next block. Every comparator keeps a sticky mismatch flag. Because the ring closes, block N-1 is compared with block 0. Every block, the end ones included, is therefore watched by exactly two comparators.

When a session ends, the flag vector is frozen and decoded into a per-block fault map. A block is reported faulty when both comparators that watch it have flagged. A status bit marks outcomes that the ring cannot resolve. The pattern source is chosen at build time: a binary counter or a Galois LFSR. Each block model has a stuck-at fault control so that the harness can be exercised.

Top module: `ccra_top`

## Requirements
- R1: After reset, the flags are all zero and busy and done are low. The pattern register holds SEED (default 1), so every unit output equals f(SEED) = 8'h03.
- R2: Each unit computes f(x) = x XOR (x rotated left by one bit). When fault_en[i] is high, bit fault_bit of unit i's output is forced to fault_val. The other units are unaffected.
- R3: A start pulse from idle or done begins a session of exactly run_len pattern cycles. During those cycles busy is high. Done then rises and busy falls.
- R4: Comparator i sets flag i when unit i and unit (i+1) mod N differ in any compared cycle. Without injected faults, no flag is set.
- R5: A flag stays set until a clear is accepted. While done is high, the flags hold even if the fault controls change.
- R6: The ring wraps around. A fault in unit N-1 sets flags N-2 and N-1, and a fault in unit 0 sets flags N-1 and 0.
- R7: fault_map[i] is high exactly when flag (i-1) mod N and flag i are both set.
- R8: unresolvable is high only while done is high. It is raised when every flag is set, or when no flag is set while any fault_en bit is high.
- R9: With PAT_MODE = PAT_LFSR, the patterns follow p' = (p >> 1) XOR (p[0] ? 8'hB8 : 0), starting from SEED. The flags then follow the same ring rule under that sequence.
- R10: While a session runs, start and clear are ignored. The session length and the flags are unchanged.
- R11: A start with run_len = 0 reaches done on the next cycle. No comparison is made and busy never rises.
- R12: A clear while idle or done zeroes the flags and drops done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a test session |
| clear | input | 1 | zero the flags and return to idle |
| run_len | input | CNT_W | pattern cycles per session |
| fault_en | input | N_UNITS | per-unit stuck-at enable |
| fault_bit | input | BIT_W | output bit forced by an enabled fault |
| fault_val | input | 1 | value forced onto that bit |
| unit_out | output | N_UNITS*DATA_W | unit outputs, unit i at bits i*DATA_W upward |
| busy | output | 1 | session in progress |
| done | output | 1 | session finished, flags frozen |
| flags | output | N_UNITS | sticky comparator flags |
| fault_map | output | N_UNITS | units diagnosed as faulty |
| unresolvable | output | 1 | flag pattern gives no unique diagnosis |

## Verification
The assertions assume three things about the inputs. Start and clear are single-cycle pulses. Reset is held high from time zero. The fault controls only change while no session runs. The bench drives every input on the falling edge, changes the fault controls only between sessions, and pulses start and clear for one cycle. The exception is the deliberate mid-session start and clear used for R10, and the rules ignore those.

// File: rtl/ccra_pkg.sv
package ccra_pkg;

    typedef enum logic [1:0] {
        SES_IDLE = 2'd0,
        SES_RUN  = 2'd1,
        SES_DONE = 2'd2
    } ses_state_e;

    typedef enum logic {
        PAT_COUNT = 1'b0,
        PAT_LFSR  = 1'b1
    } pat_mode_e;

    typedef struct packed {
        logic load;
        logic advance;
        logic cmp_en;
        logic flag_clr;
    } ses_ctl_t;

    function automatic int ring_prev(input int i, input int n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

    function automatic int ring_next(input int i, input int n);
        return (i == n - 1) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/ccra_pattern_gen.sv
module ccra_pattern_gen
    import ccra_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter pat_mode_e       MODE   = PAT_COUNT,
    parameter logic [DATA_W-1:0] SEED = 1,
    parameter logic [DATA_W-1:0] TAPS = 8'hB8
) (
    input  logic              clk,
    input  logic              rst,
    input  ses_ctl_t          ctl,
    output logic [DATA_W-1:0] pattern
);
    logic [DATA_W-1:0] pat_q;
    logic [DATA_W-1:0] pat_nxt;

    generate
        if (MODE == PAT_LFSR) begin : g_lfsr
            always_comb begin
                pat_nxt = pat_q >> 1;
                if (pat_q[0]) pat_nxt = pat_nxt ^ TAPS;
            end
        end else begin : g_count
            always_comb pat_nxt = pat_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)              pat_q <= SEED;
        else if (ctl.load)    pat_q <= SEED;
        else if (ctl.advance) pat_q <= pat_nxt;
    end

    assign pattern = pat_q;
endmodule

// File: rtl/ccra_unit.sv
module ccra_unit #(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] stim,
    input  logic              inj_en,
    input  logic [BIT_W-1:0]  inj_bit,
    input  logic              inj_val,
    output logic [DATA_W-1:0] resp
);
    always_comb begin
        resp = stim ^ {stim[DATA_W-2:0], stim[DATA_W-1]};
        if (inj_en) resp[inj_bit] = inj_val;
    end
endmodule

// File: rtl/ccra_ring_cmp.sv
module ccra_ring_cmp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic [DATA_W-1:0] side_a,
    input  logic [DATA_W-1:0] side_b,
    output logic              mismatch
);
    always_ff @(posedge clk) begin
        if (rst)                        mismatch <= 1'b0;
        else if (clr)                   mismatch <= 1'b0;
        else if (en && side_a != side_b) mismatch <= 1'b1;
    end
endmodule

// File: rtl/ccra_session_ctrl.sv
module ccra_session_ctrl
    import ccra_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clear,
    input  logic [CNT_W-1:0] run_len,
    output ses_ctl_t         ctl,
    output logic             busy,
    output logic             done
);
    ses_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic             running;

    assign running = (state_q == SES_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SES_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            case (state_q)
                SES_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q + 1'b1 == len_q) state_q <= SES_DONE;
                end
                default: begin
                    if (start) begin
                        cnt_q   <= '0;
                        len_q   <= run_len;
                        state_q <= (run_len == '0) ? SES_DONE : SES_RUN;
                    end else if (clear) begin
                        state_q <= SES_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl.load     = start && !running;
        ctl.advance  = running;
        ctl.cmp_en   = running;
        ctl.flag_clr = clear && !running;
    end

    assign busy = running;
    assign done = (state_q == SES_DONE);
endmodule

// File: rtl/ccra_diagnose.sv
module ccra_diagnose
    import ccra_pkg::*;
#(
    parameter int N_UNITS = 6
) (
    input  logic [N_UNITS-1:0] flags,
    input  logic [N_UNITS-1:0] fault_en,
    input  logic               done,
    output logic [N_UNITS-1:0] fault_map,
    output logic               unresolvable
);
    generate
        for (genvar i = 0; i < N_UNITS; i++) begin : g_map
            localparam int PREV = ring_prev(i, N_UNITS);
            assign fault_map[i] = flags[i] & flags[PREV];
        end
    endgenerate

    assign unresolvable = done && ((&flags) || (!(|flags) && (|fault_en)));
endmodule

// File: rtl/ccra_top.sv
module ccra_top
    import ccra_pkg::*;
#(
    parameter int                N_UNITS   = 6,
    parameter int                DATA_W    = 8,
    parameter int                CNT_W     = 16,
    parameter pat_mode_e         PAT_MODE  = PAT_COUNT,
    parameter logic [DATA_W-1:0] SEED      = 1,
    parameter logic [DATA_W-1:0] LFSR_TAPS = 8'hB8,
    localparam int               BIT_W     = $clog2(DATA_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      clear,
    input  logic [CNT_W-1:0]          run_len,
    input  logic [N_UNITS-1:0]        fault_en,
    input  logic [BIT_W-1:0]          fault_bit,
    input  logic                      fault_val,
    output logic [N_UNITS*DATA_W-1:0] unit_out,
    output logic                      busy,
    output logic                      done,
    output logic [N_UNITS-1:0]        flags,
    output logic [N_UNITS-1:0]        fault_map,
    output logic                      unresolvable
);
    ses_ctl_t          ctl;
    logic [DATA_W-1:0] pattern;
    logic [DATA_W-1:0] resp [N_UNITS];

    ccra_session_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .clear(clear),
        .run_len(run_len), .ctl(ctl), .busy(busy), .done(done)
    );

    ccra_pattern_gen #(
        .DATA_W(DATA_W), .MODE(PAT_MODE), .SEED(SEED), .TAPS(LFSR_TAPS)
    ) u_pat (
        .clk(clk), .rst(rst), .ctl(ctl), .pattern(pattern)
    );

    generate
        for (genvar i = 0; i < N_UNITS; i++) begin : g_ring
            localparam int NEXT = ring_next(i, N_UNITS);

            ccra_unit #(.DATA_W(DATA_W)) u_unit (
                .stim(pattern), .inj_en(fault_en[i]), .inj_bit(fault_bit),
                .inj_val(fault_val), .resp(resp[i])
            );

            ccra_ring_cmp #(.DATA_W(DATA_W)) u_cmp (
                .clk(clk), .rst(rst), .en(ctl.cmp_en), .clr(ctl.flag_clr),
                .side_a(resp[i]), .side_b(resp[NEXT]), .mismatch(flags[i])
            );

            assign unit_out[i*DATA_W +: DATA_W] = resp[i];
        end
    endgenerate

    ccra_diagnose #(.N_UNITS(N_UNITS)) u_diag (
        .flags(flags), .fault_en(fault_en), .done(done),
        .fault_map(fault_map), .unresolvable(unresolvable)
    );
endmodule

// File: rtl/ccra_checker.sv
module ccra_checker #(
    parameter int N_UNITS = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               clear,
    input logic               busy,
    input logic               done,
    input logic [N_UNITS-1:0] flags,
    input logic [N_UNITS-1:0] fault_map,
    input logic               unresolvable
);
    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R3
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R5
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(flags) & ~flags)) |-> $past(clear));

    // R5
    frozen_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(flags));

    // R7
    map_within_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_map & ~flags) == '0);

    // R8
    unres_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        unresolvable |-> done);
endmodule

bind ccra_top ccra_checker #(.N_UNITS(N_UNITS)) u_ccra_chk (
    .clk(clk), .rst(rst), .start(start), .clear(clear), .busy(busy),
    .done(done), .flags(flags), .fault_map(fault_map),
    .unresolvable(unresolvable)
);

// File: tb/ccra_top_bench.sv
module ccra_top_bench;
    localparam int N  = 6;
    localparam int W  = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          clear = 1'b0;
    logic [CW-1:0] run_len = '0;
    logic [N-1:0]  fault_en = '0;
    logic [2:0]    fault_bit = '0;
    logic          fault_val = 1'b0;

    logic [N*W-1:0] unit_out, unit_out_l;
    logic           busy, done, busy_l, done_l, unres, unres_l;
    logic [N-1:0]   flags, fmap, flags_l, fmap_l;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ccra_top u_ccra_top (
        .clk(clk), .rst(rst), .start(start), .clear(clear), .run_len(run_len),
        .fault_en(fault_en), .fault_bit(fault_bit), .fault_val(fault_val),
        .unit_out(unit_out), .busy(busy), .done(done), .flags(flags),
        .fault_map(fmap), .unresolvable(unres)
    );

    ccra_top #(.PAT_MODE(ccra_pkg::PAT_LFSR)) u_ccra_top_lfsr (
        .clk(clk), .rst(rst), .start(start), .clear(clear), .run_len(run_len),
        .fault_en(fault_en), .fault_bit(fault_bit), .fault_val(fault_val),
        .unit_out(unit_out_l), .busy(busy_l), .done(done_l), .flags(flags_l),
        .fault_map(fmap_l), .unresolvable(unres_l)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R3 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ufn(input logic [W-1:0] x, input logic fe);
        logic [W-1:0] y;
        y = x ^ {x[W-2:0], x[W-1]};
        if (fe) y[fault_bit] = fault_val;
        return y;
    endfunction

    function automatic logic [N-1:0] model(input logic lfsr, input int len);
        logic [W-1:0] p = 8'h01;
        logic [N-1:0] r = '0;
        for (int k = 0; k < len; k++) begin
            for (int i = 0; i < N; i++)
                if (ufn(p, fault_en[i]) != ufn(p, fault_en[(i+1)%N])) r[i] = 1'b1;
            if (lfsr) p = (p >> 1) ^ (p[0] ? 8'hB8 : 8'h00);
            else      p = p + 1'b1;
        end
        return r;
    endfunction

    function automatic logic [N-1:0] mapof(input logic [N-1:0] f);
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = f[i] & f[(i+N-1)%N];
        return m;
    endfunction

    task automatic pulse_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
    endtask

    // runs a session; optional mid-session start/clear pulse at busy count 3
    task automatic run_session(input int len, input logic poke, output int nbusy);
        int guard = 0;
        nbusy = 0;
        run_len = CW'(len);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && guard < 5000) begin
            if (busy) nbusy++;
            if (poke && nbusy == 3) begin start = 1'b1; clear = 1'b1; end
            else begin start = 1'b0; clear = 1'b0; end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        clear = 1'b0;
    endtask

    task automatic full_check(input string req, input int len, input logic poke);
        int nb;
        logic [N-1:0] ef, efl;
        pulse_clear();
        ef  = model(1'b0, len);
        efl = model(1'b1, len);
        run_session(len, poke, nb);
        check({req, " R3 session length"}, 64'(nb), 64'(len));
        check({req, " R4 flags"}, 64'(flags), 64'(ef));
        check({req, " R9 lfsr flags"}, 64'(flags_l), 64'(efl));
        check({req, " R7 fault map"}, 64'(fmap), 64'(mapof(ef)));
        check({req, " R8 unresolvable"}, 64'(unres),
              64'((&ef) || (ef == '0 && fault_en != '0)));
    endtask

    task automatic t_reset();
        check("R1 flags", 64'(flags), 64'h0);
        check("R1 busy", 64'(busy), 64'h0);
        check("R1 done", 64'(done), 64'h0);
        for (int i = 0; i < N; i++)
            check("R1 unit out", 64'(unit_out[i*W +: W]), 64'h03);
    endtask

    task automatic t_unit_fn();
        @(negedge clk);
        fault_en = 6'b000100; fault_bit = 3'd5; fault_val = 1'b1;
        #1;
        check("R2 faulted unit", 64'(unit_out[2*W +: W]), 64'h23);
        check("R2 clean unit", 64'(unit_out[1*W +: W]), 64'h03);
        fault_en = '0;
    endtask

    task automatic t_clean();
        fault_en = '0;
        full_check("R4 clean", 20, 1'b0);
        check("R4 no flags", 64'(flags), 64'h0);
    endtask

    task automatic t_single();
        fault_en = 6'b001000; fault_bit = 3'd0; fault_val = 1'b1;
        full_check("R7 unit3", 16, 1'b0);
        check("R7 onehot map", 64'(fmap), 64'h08);
    endtask

    task automatic t_wrap();
        fault_en = 6'b100000; fault_bit = 3'd1; fault_val = 1'b0;
        full_check("R6 unit5", 16, 1'b0);
        check("R6 flags end", 64'(flags), 64'h30);
        fault_en = 6'b000001;
        full_check("R6 unit0", 16, 1'b0);
        check("R6 flags start", 64'(flags), 64'h21);
        check("R6 map start", 64'(fmap), 64'h01);
    endtask

    task automatic t_frozen();
        logic [N-1:0] held;
        fault_en = 6'b000010; fault_bit = 3'd0; fault_val = 1'b1;
        full_check("R5 setup", 10, 1'b0);
        held = flags;
        @(negedge clk) fault_en = 6'b010100;
        repeat (5) @(negedge clk);
        check("R5 frozen flags", 64'(flags), 64'(held));
        check("R5 done held", 64'(done), 64'h1);
        pulse_clear();
        #1;
        check("R12 cleared flags", 64'(flags), 64'h0);
        check("R12 done dropped", 64'(done), 64'h0);
        fault_en = '0;
    endtask

    task automatic t_unres();
        fault_en = 6'b010101; fault_bit = 3'd0; fault_val = 1'b1;
        full_check("R8 all set", 12, 1'b0);
        check("R8 all unres", 64'(unres), 64'h1);
        fault_en = 6'b000100; fault_bit = 3'd7; fault_val = 1'b0;
        full_check("R8 none set", 3, 1'b0);
        check("R8 none unres", 64'(unres), 64'h1);
        fault_en = '0;
    endtask

    task automatic t_ignore();
        fault_en = 6'b000010; fault_bit = 3'd0; fault_val = 1'b1;
        full_check("R10 poke", 12, 1'b1);
        check("R10 flags kept", 64'(flags), 64'h03);
        fault_en = '0;
    endtask

    task automatic t_zero();
        int nb;
        fault_en = 6'b000001; fault_bit = 3'd0; fault_val = 1'b1;
        pulse_clear();
        run_session(0, 1'b0, nb);
        check("R11 no busy", 64'(nb), 64'h0);
        check("R11 done", 64'(done), 64'h1);
        check("R11 no flags", 64'(flags), 64'h0);
        fault_en = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unit_fn();
        t_clean();
        t_single();
        t_wrap();
        t_frozen();
        t_unres();
        t_ignore();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule